// File: doc/BRIEF.md
# Bus Target Register Responder

This block is the slave half of a 32-bit PCI-style interface on a network controller. On every address phase it looks at the command, the address and the slot select line. It claims configuration cycles addressed to function 0 while the slot select is high. It also claims memory cycles whose address falls inside a 128-byte window that a base-address register sets. Once it has claimed a cycle, it answers reads and takes writes, one DWORD per data phase, with bursts advancing through consecutive DWORDs.

Configuration space holds a fixed identity word and the window base register. The memory window holds a small bank of controller registers: a bus-mode register whose bit 0 requests a software reset, receive and transmit list base pointers, an operating-mode word, and a read-only status word. The status word packs the live transmit and receive process states supplied by the rest of the controller. Register contents are presented on plain output ports for the controller core.

The bus pins are split into separate input, output and output-enable signals. The pad ring joins them into the shared bidirectional lines.

Top module: `nic_pci_target`

## Requirements
- R1: After reset, tgt_oe_o and ad_oe_o are 0, soft_rst_o is 0, and bus_mode_o, rx_base_o, tx_base_o, op_mode_o and the window base all read 0.
- R2: An address phase is the rising edge on which FRAME# is low and was high at the previous edge. A configuration cycle (C/BE# 1010 read, 1011 write) is claimed only if idsel_i is high and AD[10:8] = 000 on that edge. Otherwise tgt_oe_o stays 0.
- R3: On a claimed cycle, DEVSEL# goes low in the clock after the address phase while TRDY# stays high and AD stays undriven. One clock later TRDY# goes low, and on reads AD is driven with the addressed data.
- R4: A configuration read of DWORD 0 (AD[7:2] = 0) returns 0x0981104A. DWORD 4 returns the window base with bits [6:0] zero. Every other DWORD reads 0.
- R5: A configuration write to DWORD 4 loads base bits [31:7] from the byte lanes whose C/BE# bit is 0. Writes to DWORD 0 and to other DWORDs change nothing.
- R6: A memory cycle (C/BE# 0110 read, 0111 write) is claimed only when the window base is nonzero and AD[31:7] equals base[31:7]. Other memory cycles never assert DEVSEL#.
- R7: Within the window, byte offset 0x00 is bus mode (bit 0 reads 0), 0x18 is the receive list base, 0x20 is the transmit list base and 0x30 is the operating mode. All four are read/write with per-lane byte enables. Other offsets read 0 and discard writes.
- R8: Offset 0x28 reads status: [22:20] transmit state, [19:17] receive state, [13] fatal bus error, [25:23] error type when bit 13 is 1 and 000 otherwise, all other bits 0. Writes to it are ignored.
- R9: A write to offset 0x00 with lane 0 enabled and data bit 0 = 1 clears bus mode, both list bases and the operating mode, and pulses soft_rst_o for exactly one clock. The window base is kept.
- R10: A data phase transfers only on an edge where IRDY# and TRDY# are both low, and each transfer advances the DWORD index by one. IRDY# high inserts a wait that holds the data.
- R11: After the final transfer (IRDY# low, FRAME# high, TRDY# low), the next clock has AD undriven and DEVSEL#/TRDY# driven high. The clock after that releases them (tgt_oe_o 0), unless a new cycle is claimed.
- R12: STOP# is driven high whenever the target drives its control lines.
- R13: Address phases with any command other than the four above are never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| ad_o | output | 32 | Read data driven onto the address/data lines |
| ad_oe_o | output | 1 | Output enable for ad_o |
| cbe_n_i | input | 4 | Command / byte enables, active low |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration slot select |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Target stop, active low |
| tgt_oe_o | output | 1 | Output enable for DEVSEL#, TRDY#, STOP# |
| tx_state_i | input | 3 | Transmit process state |
| rx_state_i | input | 3 | Receive process state |
| fatal_err_i | input | 1 | Fatal bus error flag |
| err_type_i | input | 3 | Bus error type |
| bus_mode_o | output | 32 | Bus mode register |
| rx_base_o | output | 32 | Receive list base |
| tx_base_o | output | 32 | Transmit list base |
| op_mode_o | output | 32 | Operating mode register |
| soft_rst_o | output | 1 | One-clock software reset pulse |

## Verification
The sensitive overlap is the clock in which one cycle is being released while the next one is decoded. An initiator may drop FRAME# for a new address phase on the edge right after the final data phase of the previous cycle. In that clock the target is still driving DEVSEL# and TRDY# high, and it must claim or ignore the new cycle in the same clock. The bench starts back-to-back cycles this way, both in directed cases and at random. In the release clock it checks that DEVSEL#, TRDY# and AD are released. In the clock after the new address phase it checks the claim or non-claim against the reference model, with the model's window base updated by any earlier configuration writes.

// File: rtl/nic_pci_pkg.sv
package nic_pci_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_DATA = 2'd2,
    ST_REL  = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  localparam logic [5:0] CFG_IDX_ID  = 6'd0;
  localparam logic [5:0] CFG_IDX_BAR = 6'd4;

  localparam logic [7:0] OFF_BUSMODE = 8'h00;
  localparam logic [7:0] OFF_RXBASE  = 8'h18;
  localparam logic [7:0] OFF_TXBASE  = 8'h20;
  localparam logic [7:0] OFF_STATUS  = 8'h28;
  localparam logic [7:0] OFF_OPMODE  = 8'h30;

  // Replace the bytes whose active-low enable is asserted.
  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] nw,
                                             input logic [3:0]  be_n);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++) begin
      if (!be_n[b]) r[8*b +: 8] = nw[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/nic_pci_seq.sv
module nic_pci_seq
  import nic_pci_pkg::*;
#(
  parameter int WIN_BITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_n_i,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic        idsel_i,
  input  logic [31:0] bar_i,
  output logic        devsel_n_o,
  output logic        trdy_n_o,
  output logic        tgt_oe_o,
  output logic        ad_oe_o,
  output logic        sel_cfg_o,
  output logic        is_wr_o,
  output logic [5:0]  idx_o,
  output logic        xfer_o
);

  tgt_state_e state_q, state_d;
  logic       frame_q;
  logic       devsel_q, devsel_d;
  logic       trdy_q, trdy_d;
  logic       oe_q, oe_d;
  logic       adoe_q, adoe_d;
  logic       cfg_q, cfg_d;
  logic       wr_q, wr_d;
  logic [5:0] idx_q, idx_d;

  logic addr_ph, cfg_hit, mem_hit, claim, xfer;

  assign addr_ph = !frame_n_i && frame_q && (state_q == ST_IDLE || state_q == ST_REL);
  assign cfg_hit = idsel_i && (ad_i[10:8] == 3'b000) &&
                   (cbe_n_i == CMD_CFG_RD || cbe_n_i == CMD_CFG_WR);
  assign mem_hit = (cbe_n_i == CMD_MEM_RD || cbe_n_i == CMD_MEM_WR) &&
                   (|bar_i[31:WIN_BITS]) &&
                   (ad_i[31:WIN_BITS] == bar_i[31:WIN_BITS]);
  assign claim   = addr_ph && (cfg_hit || mem_hit);
  assign xfer    = (state_q == ST_DATA) && !irdy_n_i && !trdy_q;

  always_comb begin
    state_d  = state_q;
    devsel_d = devsel_q;
    trdy_d   = trdy_q;
    oe_d     = oe_q;
    adoe_d   = adoe_q;
    cfg_d    = cfg_q;
    wr_d     = wr_q;
    idx_d    = idx_q;
    unique case (state_q)
      ST_IDLE, ST_REL: begin
        devsel_d = 1'b1;
        trdy_d   = 1'b1;
        oe_d     = 1'b0;
        state_d  = ST_IDLE;
        if (claim) begin
          state_d  = ST_ACK;
          devsel_d = 1'b0;
          oe_d     = 1'b1;
          cfg_d    = cfg_hit;
          wr_d     = cbe_n_i[0];
          idx_d    = ad_i[7:2];
        end
      end
      ST_ACK: begin
        state_d = ST_DATA;
        trdy_d  = 1'b0;
        adoe_d  = !wr_q;
      end
      ST_DATA: begin
        if (xfer) begin
          idx_d = idx_q + 6'd1;
          if (frame_n_i) begin
            state_d  = ST_REL;
            trdy_d   = 1'b1;
            devsel_d = 1'b1;
            adoe_d   = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= 1'b1;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      oe_q     <= 1'b0;
      adoe_q   <= 1'b0;
      cfg_q    <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
    end else begin
      state_q  <= state_d;
      frame_q  <= frame_n_i;
      devsel_q <= devsel_d;
      trdy_q   <= trdy_d;
      oe_q     <= oe_d;
      adoe_q   <= adoe_d;
      cfg_q    <= cfg_d;
      wr_q     <= wr_d;
      idx_q    <= idx_d;
    end
  end

  assign devsel_n_o = devsel_q;
  assign trdy_n_o   = trdy_q;
  assign tgt_oe_o   = oe_q;
  assign ad_oe_o    = adoe_q;
  assign sel_cfg_o  = cfg_q;
  assign is_wr_o    = wr_q;
  assign idx_o      = idx_q;
  assign xfer_o     = xfer;

endmodule

// File: rtl/nic_pci_cfg.sv
module nic_pci_cfg
  import nic_pci_pkg::*;
#(
  parameter int          WIN_BITS = 7,
  parameter logic [31:0] ID_WORD  = 32'h0981104A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [5:0]  idx_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_n_i,
  output logic [31:0] rdata_o,
  output logic [31:0] bar_o
);

  localparam int BAR_W = 32 - WIN_BITS;

  logic [BAR_W-1:0] bar_q, bar_d;
  logic [31:0]      bar_full, bar_new;

  assign bar_full = {bar_q, {WIN_BITS{1'b0}}};
  assign bar_new  = lane_merge(bar_full, wdata_i, be_n_i);

  always_comb begin
    bar_d = bar_q;
    if (we_i && idx_i == CFG_IDX_BAR) bar_d = bar_new[31:WIN_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bar_q <= '0;
    else        bar_q <= bar_d;
  end

  always_comb begin
    unique case (idx_i)
      CFG_IDX_ID:  rdata_o = ID_WORD;
      CFG_IDX_BAR: rdata_o = bar_full;
      default:     rdata_o = '0;
    endcase
  end

  assign bar_o = bar_full;

endmodule

// File: rtl/nic_pci_csr.sv
module nic_pci_csr
  import nic_pci_pkg::*;
#(
  parameter int WIN_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [WIN_BITS-3:0] idx_i,
  input  logic [31:0]         wdata_i,
  input  logic [3:0]          be_n_i,
  input  logic [2:0]          tx_state_i,
  input  logic [2:0]          rx_state_i,
  input  logic                fatal_err_i,
  input  logic [2:0]          err_type_i,
  output logic [31:0]         rdata_o,
  output logic [31:0]         bus_mode_o,
  output logic [31:0]         rx_base_o,
  output logic [31:0]         tx_base_o,
  output logic [31:0]         op_mode_o,
  output logic                soft_rst_o
);

  logic [7:0]  off;
  logic [31:0] bm_q, bm_d, rx_q, rx_d, tx_q, tx_d, om_q, om_d;
  logic        sr_q, sr_d;
  logic [31:0] status;

  assign off = 8'(idx_i) << 2;

  always_comb begin
    status        = '0;
    status[22:20] = tx_state_i;
    status[19:17] = rx_state_i;
    status[13]    = fatal_err_i;
    if (fatal_err_i) status[25:23] = err_type_i;
  end

  always_comb begin
    bm_d = bm_q;
    rx_d = rx_q;
    tx_d = tx_q;
    om_d = om_q;
    sr_d = 1'b0;
    if (we_i) begin
      unique case (off)
        OFF_BUSMODE: begin
          if (!be_n_i[0] && wdata_i[0]) begin
            sr_d = 1'b1;
            bm_d = '0;
            rx_d = '0;
            tx_d = '0;
            om_d = '0;
          end else begin
            bm_d = lane_merge(bm_q, wdata_i, be_n_i) & ~32'd1;
          end
        end
        OFF_RXBASE: rx_d = lane_merge(rx_q, wdata_i, be_n_i);
        OFF_TXBASE: tx_d = lane_merge(tx_q, wdata_i, be_n_i);
        OFF_OPMODE: om_d = lane_merge(om_q, wdata_i, be_n_i);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_q <= '0;
      rx_q <= '0;
      tx_q <= '0;
      om_q <= '0;
      sr_q <= 1'b0;
    end else begin
      bm_q <= bm_d;
      rx_q <= rx_d;
      tx_q <= tx_d;
      om_q <= om_d;
      sr_q <= sr_d;
    end
  end

  always_comb begin
    unique case (off)
      OFF_BUSMODE: rdata_o = bm_q;
      OFF_RXBASE:  rdata_o = rx_q;
      OFF_TXBASE:  rdata_o = tx_q;
      OFF_STATUS:  rdata_o = status;
      OFF_OPMODE:  rdata_o = om_q;
      default:     rdata_o = '0;
    endcase
  end

  assign bus_mode_o = bm_q;
  assign rx_base_o  = rx_q;
  assign tx_base_o  = tx_q;
  assign op_mode_o  = om_q;
  assign soft_rst_o = sr_q;

endmodule

// File: rtl/nic_pci_target.sv
module nic_pci_target
  import nic_pci_pkg::*;
#(
  parameter int          WIN_BITS = 7,
  parameter logic [31:0] ID_WORD  = 32'h0981104A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  input  logic [3:0]  cbe_n_i,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic        idsel_i,
  output logic        devsel_n_o,
  output logic        trdy_n_o,
  output logic        stop_n_o,
  output logic        tgt_oe_o,
  input  logic [2:0]  tx_state_i,
  input  logic [2:0]  rx_state_i,
  input  logic        fatal_err_i,
  input  logic [2:0]  err_type_i,
  output logic [31:0] bus_mode_o,
  output logic [31:0] rx_base_o,
  output logic [31:0] tx_base_o,
  output logic [31:0] op_mode_o,
  output logic        soft_rst_o
);

  localparam int CSR_IDX_W = WIN_BITS - 2;

  logic [1:0]  rst_sync;
  logic        rst_int_n;
  logic [31:0] bar, cfg_rdata, csr_rdata;
  logic        sel_cfg, is_wr, xfer;
  logic [5:0]  idx;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  nic_pci_seq #(.WIN_BITS(WIN_BITS)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .idsel_i(idsel_i),
    .bar_i(bar), .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o),
    .tgt_oe_o(tgt_oe_o), .ad_oe_o(ad_oe_o), .sel_cfg_o(sel_cfg),
    .is_wr_o(is_wr), .idx_o(idx), .xfer_o(xfer)
  );

  nic_pci_cfg #(.WIN_BITS(WIN_BITS), .ID_WORD(ID_WORD)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we_i(xfer && is_wr && sel_cfg),
    .idx_i(idx), .wdata_i(ad_i), .be_n_i(cbe_n_i),
    .rdata_o(cfg_rdata), .bar_o(bar)
  );

  nic_pci_csr #(.WIN_BITS(WIN_BITS)) u_csr (
    .clk(clk), .rst_n(rst_int_n), .we_i(xfer && is_wr && !sel_cfg),
    .idx_i(idx[CSR_IDX_W-1:0]), .wdata_i(ad_i), .be_n_i(cbe_n_i),
    .tx_state_i(tx_state_i), .rx_state_i(rx_state_i),
    .fatal_err_i(fatal_err_i), .err_type_i(err_type_i),
    .rdata_o(csr_rdata), .bus_mode_o(bus_mode_o), .rx_base_o(rx_base_o),
    .tx_base_o(tx_base_o), .op_mode_o(op_mode_o), .soft_rst_o(soft_rst_o)
  );

  assign ad_o     = sel_cfg ? cfg_rdata : csr_rdata;
  assign stop_n_o = 1'b1;

endmodule

// File: rtl/nic_pci_target_chk.sv
module nic_pci_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ad_i,
  input logic [3:0]  cbe_n_i,
  input logic        frame_n_i,
  input logic        irdy_n_i,
  input logic        idsel_i,
  input logic        ad_oe_o,
  input logic        devsel_n_o,
  input logic        trdy_n_o,
  input logic        stop_n_o,
  input logic        tgt_oe_o,
  input logic        soft_rst_o,
  input logic [31:0] op_mode_o,
  input logic [31:0] rx_base_o
);

  // R2: configuration cycle without slot select is never claimed
  p_cfg_no_idsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_i && $past(frame_n_i) && !idsel_i && cbe_n_i[3:1] == 3'b101)
    |=> !(tgt_oe_o && !devsel_n_o));

  // R2: configuration read to function 0 with slot select is claimed
  p_cfg_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_i && $past(frame_n_i) && idsel_i && cbe_n_i == 4'b1010 && ad_i[10:8] == 3'b000)
    |=> (tgt_oe_o && !devsel_n_o));

  // R3: TRDY# is only asserted under DEVSEL#
  p_trdy_under_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_oe_o && !trdy_n_o) |-> !devsel_n_o);

  // R3: AD is driven only after a turnaround clock with DEVSEL# already driven
  p_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe_o) |-> ($past(tgt_oe_o) && $past(trdy_n_o)));

  // R11: final transfer is followed by a release clock
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_oe_o && !trdy_n_o && !irdy_n_i && frame_n_i)
    |=> (!ad_oe_o && devsel_n_o && trdy_n_o && tgt_oe_o));

  // R12: STOP# stays high while driven
  p_stop_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_oe_o |-> stop_n_o);

  // R9: software reset pulse comes with cleared registers
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (op_mode_o == 32'd0 && rx_base_o == 32'd0));

  // R13: unknown commands are never claimed
  p_other_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_i && $past(frame_n_i) && cbe_n_i != 4'b1010 && cbe_n_i != 4'b1011 &&
     cbe_n_i != 4'b0110 && cbe_n_i != 4'b0111)
    |=> !(tgt_oe_o && !devsel_n_o));

endmodule

bind nic_pci_target nic_pci_target_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
  .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .idsel_i(idsel_i),
  .ad_oe_o(ad_oe_o), .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o),
  .stop_n_o(stop_n_o), .tgt_oe_o(tgt_oe_o), .soft_rst_o(soft_rst_o),
  .op_mode_o(op_mode_o), .rx_base_o(rx_base_o)
);

// File: tb/test_nic_pci_target.sv
module test_nic_pci_target;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad_i, ad_o;
  logic        ad_oe_o;
  logic [3:0]  cbe_n_i;
  logic        frame_n_i, irdy_n_i, idsel_i;
  logic        devsel_n_o, trdy_n_o, stop_n_o, tgt_oe_o;
  logic [2:0]  tx_state_i, rx_state_i, err_type_i;
  logic        fatal_err_i;
  logic [31:0] bus_mode_o, rx_base_o, tx_base_o, op_mode_o;
  logic        soft_rst_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_pci_target i_nic_pci_target (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .cbe_n_i(cbe_n_i), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .idsel_i(idsel_i), .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o),
    .stop_n_o(stop_n_o), .tgt_oe_o(tgt_oe_o), .tx_state_i(tx_state_i),
    .rx_state_i(rx_state_i), .fatal_err_i(fatal_err_i), .err_type_i(err_type_i),
    .bus_mode_o(bus_mode_o), .rx_base_o(rx_base_o), .tx_base_o(tx_base_o),
    .op_mode_o(op_mode_o), .soft_rst_o(soft_rst_o)
  );

  int nchk = 0;
  int nerr = 0;
  bit pend_sr = 0;
  bit prev_b2b = 0;
  logic [31:0] dbuf [16];
  logic [3:0]  bebuf [16];

  // reference model state
  logic [31:0] m_bar = 0, m_bm = 0, m_rx = 0, m_tx = 0, m_om = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // every negedge: R9 pulse seen only right after a reset write
  task automatic step();
    @(negedge clk);
    chk("R9 soft reset pulse", {31'b0, soft_rst_o}, {31'b0, pend_sr});
    pend_sr = 0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (!be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic bit claim_exp(input logic [3:0] cmd, input logic [31:0] a, input bit sel);
    if (cmd == 4'b1010 || cmd == 4'b1011) return sel && a[10:8] == 3'b000;
    if (cmd == 4'b0110 || cmd == 4'b0111) return m_bar != 0 && a[31:7] == m_bar[31:7];
    return 0;
  endfunction

  function automatic logic [31:0] status_exp();
    logic [31:0] s = 0;
    s[22:20] = tx_state_i;
    s[19:17] = rx_state_i;
    s[13] = fatal_err_i;
    if (fatal_err_i) s[25:23] = err_type_i;
    return s;
  endfunction

  function automatic logic [31:0] read_exp(input bit cfg, input int idx);
    if (cfg) begin
      if ((idx & 63) == 0) return 32'h0981104A;
      if ((idx & 63) == 4) return m_bar;
      return 0;
    end
    case (idx & 31)
      0: return m_bm;
      6: return m_rx;
      8: return m_tx;
      10: return status_exp();
      12: return m_om;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_write(input bit cfg, input int idx, input logic [31:0] d,
                                     input logic [3:0] be);
    logic [31:0] t;
    if (cfg) begin
      if ((idx & 63) == 4) begin
        t = merge(m_bar, d, be);
        m_bar = {t[31:7], 7'b0};
      end
      return 0;
    end
    case (idx & 31)
      0: begin
        if (!be[0] && d[0]) begin
          m_bm = 0; m_rx = 0; m_tx = 0; m_om = 0;
          return 1;
        end
        m_bm = merge(m_bm, d, be) & ~32'd1;
      end
      6: m_rx = merge(m_rx, d, be);
      8: m_tx = merge(m_tx, d, be);
      12: m_om = merge(m_om, d, be);
      default: ;
    endcase
    return 0;
  endfunction

  task automatic check_regs();
    chk("R7 bus mode port", bus_mode_o, m_bm);
    chk("R7 rx base port", rx_base_o, m_rx);
    chk("R7 tx base port", tx_base_o, m_tx);
    chk("R7 op mode port", op_mode_o, m_om);
  endtask

  task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                      input int n, input bit b2b, input bit waits);
    bit cl = claim_exp(cmd, addr, sel);
    bit cfg = cmd[3];
    bit wr = cmd[0];
    int idx = cfg ? int'(addr[7:2]) : int'(addr[6:2]);
    int k = 0;
    if (!prev_b2b) step();
    prev_b2b = 0;
    frame_n_i = 0; irdy_n_i = 1; ad_i = addr; cbe_n_i = cmd; idsel_i = sel;
    step();
    if (!cl) begin
      chk("R2/R6/R13 not claimed", {31'b0, tgt_oe_o}, 32'd0);
      frame_n_i = 1; irdy_n_i = 0; idsel_i = 0; cbe_n_i = 0;
      step();
      chk("R6 no DEVSEL on miss", {31'b0, tgt_oe_o}, 32'd0);
      irdy_n_i = 1;
      step();
      chk("R13 still idle", {31'b0, tgt_oe_o}, 32'd0);
      check_regs();
      return;
    end
    chk("R3 DEVSEL low after address", {31'b0, devsel_n_o}, 32'd0);
    chk("R3 target drives controls", {31'b0, tgt_oe_o}, 32'd1);
    chk("R3 TRDY high in turnaround", {31'b0, trdy_n_o}, 32'd1);
    chk("R3 AD undriven in turnaround", {31'b0, ad_oe_o}, 32'd0);
    chk("R12 STOP high", {31'b0, stop_n_o}, 32'd1);
    idsel_i = 0; irdy_n_i = 0; frame_n_i = 0;
    cbe_n_i = wr ? bebuf[0] : 4'b0000;
    ad_i = wr ? dbuf[0] : 32'h0;
    step();
    while (k < n) begin
      chk("R3 TRDY low in data", {31'b0, trdy_n_o}, 32'd0);
      if (!wr) begin
        chk("R3 AD driven on read", {31'b0, ad_oe_o}, 32'd1);
        chk(cfg ? "R4 config read data" : "R7/R8 register read data", ad_o, read_exp(cfg, idx + k));
      end
      if (waits && $urandom_range(3) == 0) begin
        irdy_n_i = 1; frame_n_i = 0;
        step();
        continue;
      end
      irdy_n_i = 0;
      frame_n_i = (k == n - 1);
      if (wr) begin
        ad_i = dbuf[k]; cbe_n_i = bebuf[k];
        pend_sr = model_write(cfg, idx + k, dbuf[k], bebuf[k]);
      end
      step();
      k++;
    end
    chk("R11 AD released", {31'b0, ad_oe_o}, 32'd0);
    chk("R11 DEVSEL high", {31'b0, devsel_n_o}, 32'd1);
    chk("R11 TRDY high", {31'b0, trdy_n_o}, 32'd1);
    chk("R11 controls still driven", {31'b0, tgt_oe_o}, 32'd1);
    check_regs();
    if (b2b) begin
      prev_b2b = 1;
      return;
    end
    frame_n_i = 1; irdy_n_i = 1;
    step();
    chk("R11 controls released", {31'b0, tgt_oe_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; ad_i = 0; cbe_n_i = 4'hF; frame_n_i = 1; irdy_n_i = 1; idsel_i = 0;
    tx_state_i = 0; rx_state_i = 0; fatal_err_i = 0; err_type_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) step();
    // R1 reset state
    chk("R1 tgt_oe", {31'b0, tgt_oe_o}, 32'd0);
    chk("R1 ad_oe", {31'b0, ad_oe_o}, 32'd0);
    chk("R1 soft_rst", {31'b0, soft_rst_o}, 32'd0);
    check_regs();

    // R4 identity word; R2 claim rules
    xact(4'b1010, 32'h0, 1, 1, 0, 0);
    xact(4'b1010, 32'h0, 0, 1, 0, 0);          // R2 no slot select
    xact(4'b1010, 32'h0000_0100, 1, 1, 0, 0);  // R2 function 1
    xact(4'b0110, 32'h0000_0000, 0, 1, 0, 0);  // R6 base zero
    xact(4'b1010, 32'h0000_0010, 1, 1, 0, 0);  // R4 base reads 0
    // R5 program base, DWORD 0 write ignored
    dbuf[0] = 32'h1234_5678; bebuf[0] = 4'b0000;
    xact(4'b1011, 32'h0000_0010, 1, 1, 0, 0);
    dbuf[0] = 32'hFFFF_FFFF; bebuf[0] = 4'b0000;
    xact(4'b1011, 32'h0000_0000, 1, 1, 0, 0);
    xact(4'b1010, 32'h0000_0000, 1, 2, 0, 0);  // R4/R10 burst over DWORD 0,1
    xact(4'b1010, 32'h0000_0010, 1, 1, 0, 0);  // R5 readback
    // R7/R10 write burst 0x18,0x1C,0x20
    dbuf[0] = 32'hA5A5_0001; dbuf[1] = 32'hDEAD_BEEF; dbuf[2] = 32'h4000_0000;
    bebuf[0] = 4'b0000; bebuf[1] = 4'b0000; bebuf[2] = 4'b0000;
    xact(4'b0111, m_bar | 32'h18, 0, 3, 0, 0);
    xact(4'b0110, m_bar | 32'h18, 0, 3, 0, 1); // R10 with waits
    // R7 partial byte lanes
    dbuf[0] = 32'h1122_3344; bebuf[0] = 4'b1010;
    xact(4'b0111, m_bar | 32'h30, 0, 1, 0, 0);
    // R6 outside window
    xact(4'b0111, m_bar ^ 32'h8000_0000, 0, 1, 0, 0);
    // R8 status without and with fatal flag, write ignored
    tx_state_i = 3'd3; rx_state_i = 3'd5; err_type_i = 3'd6; fatal_err_i = 0;
    xact(4'b0110, m_bar | 32'h28, 0, 1, 0, 0);
    fatal_err_i = 1;
    xact(4'b0110, m_bar | 32'h28, 0, 1, 0, 0);
    dbuf[0] = 32'hFFFF_FFFF; bebuf[0] = 4'b0000;
    xact(4'b0111, m_bar | 32'h28, 0, 1, 0, 0);
    xact(4'b0110, m_bar | 32'h28, 0, 1, 0, 0);
    // R13 other command
    xact(4'b0010, m_bar | 32'h18, 1, 1, 0, 0);
    // R9 software reset, base kept
    dbuf[0] = 32'h0000_0001; bebuf[0] = 4'b1110;
    xact(4'b0111, m_bar, 0, 1, 0, 0);
    xact(4'b1010, 32'h0000_0010, 1, 1, 0, 0);
    // back-to-back: write mode then read it, then a miss straight after
    dbuf[0] = 32'h0000_2202; bebuf[0] = 4'b0000;
    xact(4'b0111, m_bar | 32'h30, 0, 1, 1, 0);
    xact(4'b0110, m_bar | 32'h30, 0, 1, 1, 0);
    xact(4'b0110, 32'h0000_0040, 0, 1, 0, 0);

    // random phase
    for (int it = 0; it < 120; it++) begin
      logic [3:0]  cmd;
      logic [31:0] a;
      bit sel;
      int n;
      case ($urandom_range(5))
        0: cmd = 4'b1010;
        1: cmd = 4'b1011;
        2, 3: cmd = $urandom_range(1) ? 4'b0110 : 4'b0111;
        4: cmd = 4'b0111;
        default: cmd = 4'($urandom_range(15));
      endcase
      sel = ($urandom_range(4) != 0);
      if (cmd[3]) begin
        a = {21'b0, ($urandom_range(4) == 0) ? 3'($urandom_range(7)) : 3'b000,
             6'($urandom_range(7)), 2'b00};
      end else if (m_bar != 0 && $urandom_range(3) != 0) begin
        a = {m_bar[31:7], 5'($urandom_range(31)), 2'b00};
      end else begin
        a = $urandom;
      end
      n = $urandom_range(1, 3);
      for (int j = 0; j < 3; j++) begin
        dbuf[j] = $urandom;
        bebuf[j] = 4'($urandom_range(15));
      end
      tx_state_i = 3'($urandom_range(7));
      rx_state_i = 3'($urandom_range(7));
      fatal_err_i = 1'($urandom_range(1));
      err_type_i = 3'($urandom_range(7));
      xact(cmd, a, sel, n, ($urandom_range(2) == 0) && it < 119, 1);
    end
    step();
    finish_run();
  end

endmodule